// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block collects 32 interrupt request lines and presents them to a processor through two independent banks of registers. One bank drives the normal interrupt request output. The other drives a separate fast interrupt request output. Each bank is programmed separately, so a line may be routed to either output, to both, or to neither.

Every line in every bank has its own trigger setting: high level, low level, rising edge or falling edge. Edge-triggered lines hold their event in a latch until software acknowledges it by writing a one to that line's bit. Level-triggered lines simply follow the input. A per-line enable decides whether a pending line reaches the bank's status view and its interrupt output.

Software reads the status register of a bank, services the lowest set bit, and reads again until the register returns zero. The register port is a plain 32-bit read/write port with a single valid strobe. Reads are combinational and writes take effect at the clock edge.

Top module: `dual_bank_intc`

## Requirements
- R1: While reset is asserted, and right after it, the enable, trigger-kind and polarity registers of both banks read 0, both status registers read 0, and both interrupt outputs are low.
- R2: The word address selects the bank with bit 3 (0 = normal, 1 = fast) and the register with bits 2:0: 0 adjusted input view, 1 enable, 2 acknowledge, 3 trigger kind, 4 polarity, 5 status. Enable, trigger kind and polarity read back the last value written to them. The acknowledge register and the unused codes 6 and 7 read 0.
- R3: The adjusted input view of a bank reads each input level XOR that bank's polarity bit.
- R4: For a line in level mode (trigger-kind bit 0), the status bit equals the adjusted input ANDed with the enable bit, and it follows the input in the same cycle. Polarity 0 means active high and polarity 1 means active low. Each interrupt output is high exactly when its bank's status is nonzero.
- R5: For a line in edge mode (trigger-kind bit 1), a rising edge (polarity 0) or a falling edge (polarity 1) is detected by comparing the input with its value in the previous cycle. The edge sets a latch that is visible in status after the next clock edge, and the latch stays set after the input returns. The opposite transition sets nothing.
- R6: Writing the acknowledge register clears the edge latch of every line whose written bit is 1. Bits written as 0 leave their latches unchanged.
- R7: If an acknowledge of a line and a new selected edge on that line occur in the same cycle, the latch remains set.
- R8: Writing the acknowledge register has no effect on level-mode lines. Their pending state keeps following the input.
- R9: A line whose enable bit is 0 does not appear in status and does not drive the output. Its edge latch still holds, so the line appears once it is enabled again.
- R10: The two banks are independent. Setting up or triggering a line in one bank does not change the other bank's status or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 4 | Word address: bit 3 selects the bank, bits 2:0 select the register |
| bus_wdata | input | 32 | Write data, one bit per line |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_lines | input | 32 | Interrupt inputs, already synchronous to clk |
| irq_norm | output | 1 | Normal interrupt request, active high |
| irq_fast | output | 1 | Fast interrupt request, active high |

## Verification
The bench drives the opposite transition on a falling-edge line and checks that it is ignored. A detector that ignored polarity would latch on it. It also raises a line in the same cycle as its acknowledge, which catches a design where the acknowledge takes priority and loses the new event. An all-ones acknowledge is written while a level line is active, and an edge latch is masked and then unmasked. These expose designs that clear level lines or that gate the latch itself with the enable. Fast-bank activity is checked against the normal output, which catches decoders that let one bank's access leak into the other.

// File: rtl/intc_pkg.sv
package intc_pkg;

   // register select codes inside one bank (word address bits 2:0)
   typedef enum logic [2:0] {
      SEL_SRC  = 3'd0,
      SEL_MASK = 3'd1,
      SEL_ACK  = 3'd2,
      SEL_KIND = 3'd3,
      SEL_POL  = 3'd4,
      SEL_STAT = 3'd5
   } intc_sel_e;

   localparam int unsigned INTC_BANKS  = 2;
   localparam int unsigned BANK_NORMAL = 0;
   localparam int unsigned BANK_FAST   = 1;

endpackage

// File: rtl/intc_pending.sv
module intc_pending #(
   parameter int unsigned NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lines,
   input  logic [NUM_LINES-1:0] prev_lines,
   input  logic [NUM_LINES-1:0] kind,
   input  logic [NUM_LINES-1:0] pol,
   input  logic [NUM_LINES-1:0] ack,
   output logic [NUM_LINES-1:0] adj,
   output logic [NUM_LINES-1:0] pend
);

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic adj_now;
      logic adj_old;
      logic hit;
      logic latch_q;

      assign adj_now = lines[i] ^ pol[i];
      assign adj_old = prev_lines[i] ^ pol[i];
      assign hit     = adj_now & ~adj_old;

      // a new edge beats a same-cycle acknowledge
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            latch_q <= 1'b0;
         else if (!kind[i])
            latch_q <= 1'b0;
         else
            latch_q <= hit | (latch_q & ~ack[i]);
      end

      assign adj[i]  = adj_now;
      assign pend[i] = kind[i] ? latch_q : adj_now;
   end

endmodule

// File: rtl/intc_bank.sv
module intc_bank
   import intc_pkg::*;
#(
   parameter int unsigned NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lines,
   input  logic [NUM_LINES-1:0] prev_lines,
   input  logic                 wr_en,
   input  intc_sel_e            wr_sel,
   input  logic [NUM_LINES-1:0] wdata,
   output logic [NUM_LINES-1:0] src,
   output logic [NUM_LINES-1:0] mask,
   output logic [NUM_LINES-1:0] kind,
   output logic [NUM_LINES-1:0] pol,
   output logic [NUM_LINES-1:0] pend,
   output logic [NUM_LINES-1:0] status,
   output logic                 irq
);

   logic [NUM_LINES-1:0] mask_q, kind_q, pol_q, ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         kind_q <= '0;
         pol_q  <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_MASK: mask_q <= wdata;
            SEL_KIND: kind_q <= wdata;
            SEL_POL:  pol_q  <= wdata;
            default:  ;
         endcase
      end
   end

   assign ack = (wr_en && wr_sel == SEL_ACK) ? wdata : '0;

   intc_pending #(.NUM_LINES(NUM_LINES)) u_pending (
      .clk        (clk),
      .rst_n      (rst_n),
      .lines      (lines),
      .prev_lines (prev_lines),
      .kind       (kind_q),
      .pol        (pol_q),
      .ack        (ack),
      .adj        (src),
      .pend       (pend)
   );

   assign mask   = mask_q;
   assign kind   = kind_q;
   assign pol    = pol_q;
   assign status = pend & mask_q;
   assign irq    = |status;

endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
   import intc_pkg::*;
#(
   parameter int unsigned NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_valid,
   input  logic                 bus_write,
   input  logic [3:0]           bus_waddr,
   input  logic [NUM_LINES-1:0] bus_wdata,
   output logic [NUM_LINES-1:0] bus_rdata,
   input  logic [NUM_LINES-1:0] irq_lines,
   output logic                 irq_norm,
   output logic                 irq_fast
);

   if (NUM_LINES < 1 || NUM_LINES > 32) begin : g_bad_width
      $error("dual_bank_intc: NUM_LINES must lie in 1..32");
   end

   localparam int unsigned BANK_BIT = 3;

   logic [NUM_LINES-1:0]                  prev_q;
   logic [INTC_BANKS-1:0][NUM_LINES-1:0]  bank_src, bank_mask, bank_kind;
   logic [INTC_BANKS-1:0][NUM_LINES-1:0]  bank_pol, bank_pend, bank_stat;
   logic [INTC_BANKS-1:0]                 bank_irq;
   intc_sel_e                             sel;
   logic                                  bsel;

   assign sel  = intc_sel_e'(bus_waddr[2:0]);
   assign bsel = bus_waddr[BANK_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= irq_lines;
   end

   for (genvar b = 0; b < INTC_BANKS; b++) begin : g_bank
      logic wr_hit;
      assign wr_hit = bus_valid && bus_write && (bsel == 1'(b));

      intc_bank #(.NUM_LINES(NUM_LINES)) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .lines      (irq_lines),
         .prev_lines (prev_q),
         .wr_en      (wr_hit),
         .wr_sel     (sel),
         .wdata      (bus_wdata),
         .src        (bank_src[b]),
         .mask       (bank_mask[b]),
         .kind       (bank_kind[b]),
         .pol        (bank_pol[b]),
         .pend       (bank_pend[b]),
         .status     (bank_stat[b]),
         .irq        (bank_irq[b])
      );
   end

   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_SRC:  bus_rdata = bank_src[bsel];
         SEL_MASK: bus_rdata = bank_mask[bsel];
         SEL_KIND: bus_rdata = bank_kind[bsel];
         SEL_POL:  bus_rdata = bank_pol[bsel];
         SEL_STAT: bus_rdata = bank_stat[bsel];
         default:  bus_rdata = '0;
      endcase
   end

   assign irq_norm = bank_irq[BANK_NORMAL];
   assign irq_fast = bank_irq[BANK_FAST];

endmodule

// File: rtl/dual_bank_intc_chk.sv
module dual_bank_intc_chk #(
   parameter int unsigned N = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         bus_valid,
   input logic         bus_write,
   input logic [3:0]   bus_waddr,
   input logic [N-1:0] bus_rdata,
   input logic [N-1:0] irq_lines,
   input logic         irq_norm,
   input logic         irq_fast,
   input logic [N-1:0] pend0,
   input logic [N-1:0] kind0,
   input logic [N-1:0] pol0,
   input logic [N-1:0] mask0
);

   logic rd, wr_ack0, wr_kind0;
   assign rd       = bus_valid && !bus_write;
   assign wr_ack0  = bus_valid && bus_write && bus_waddr == 4'd2;
   assign wr_kind0 = bus_valid && bus_write && bus_waddr == 4'd3;

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!irq_norm && !irq_fast); // R1
      end
   end

   AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_waddr[2:0] == 3'd2) |-> (bus_rdata == '0)); // R2

   AST_NORM_STAT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_waddr == 4'd5) |-> ((bus_rdata != '0) == irq_norm)); // R4

   AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ack0 && !wr_kind0) |=> (($past(pend0) & kind0 & ~pend0) == '0)); // R5

   AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend0 ^ irq_lines ^ pol0) & ~kind0) == '0); // R8

   AST_MASK_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_waddr == 4'd5) |-> ((bus_rdata & ~mask0) == '0)); // R9

   AST_FAST_STAT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_waddr == 4'd13) |-> ((bus_rdata != '0) == irq_fast)); // R10

endmodule

bind dual_bank_intc dual_bank_intc_chk #(.N(NUM_LINES)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_waddr (bus_waddr),
   .bus_rdata (bus_rdata),
   .irq_lines (irq_lines),
   .irq_norm  (irq_norm),
   .irq_fast  (irq_fast),
   .pend0     (bank_pend[0]),
   .kind0     (bank_kind[0]),
   .pol0      (bank_pol[0]),
   .mask0     (bank_mask[0])
);

// File: tb/test_dual_bank_intc.sv
module test_dual_bank_intc;

   localparam int CLK_P = 10;

   localparam logic [3:0] A_SRC  = 4'd0,  A_MASK  = 4'd1,  A_ACK  = 4'd2;
   localparam logic [3:0] A_KIND = 4'd3,  A_POL   = 4'd4,  A_STAT = 4'd5;
   localparam logic [3:0] F_SRC  = 4'd8,  F_MASK  = 4'd9,  F_ACK  = 4'd10;
   localparam logic [3:0] F_KIND = 4'd11, F_POL   = 4'd12, F_STAT = 4'd13;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [3:0]  bus_waddr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] irq_lines = '0;
   logic        irq_norm, irq_fast;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } sb_item_t;
   sb_item_t sb_q[$];

   dual_bank_intc #(.NUM_LINES(32)) i_dual_bank_intc (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_waddr (bus_waddr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_lines (irq_lines),
      .irq_norm  (irq_norm),
      .irq_fast  (irq_fast)
   );

   always #(CLK_P/2) clk = ~clk;

   // monitor: compare read data against the scoreboard
   always @(negedge clk) begin
      #(CLK_P/4);
      if (bus_valid && !bus_write) begin
         checks++;
         if (sb_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard: unexpected read, actual %h expected none", bus_rdata);
         end else begin
            sb_item_t it;
            it = sb_q.pop_front();
            if (bus_rdata !== it.exp) begin
               errors++;
               $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_waddr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
      sb_item_t it;
      it.exp = e; it.tag = tag;
      @(negedge clk);
      sb_q.push_back(it);
      bus_valid = 1'b1; bus_write = 1'b0; bus_waddr = a;
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   task automatic set_lines(input logic [31:0] v);
      @(negedge clk);
      irq_lines = v;
   endtask

   task automatic chk_irq(input logic en, input logic ef, input string tag);
      @(negedge clk);
      #(CLK_P/4);
      checks++;
      if (irq_norm !== en || irq_fast !== ef) begin
         errors++;
         $display("FAIL %s: actual norm=%b fast=%b expected norm=%b fast=%b",
                  tag, irq_norm, irq_fast, en, ef);
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual still running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 3);
      chk_irq(1'b0, 1'b0, "R1 outputs in reset");
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_MASK, 32'h0, "R1 normal enable");
      rd(A_KIND, 32'h0, "R1 normal kind");
      rd(F_POL,  32'h0, "R1 fast polarity");
      rd(A_STAT, 32'h0, "R1 normal status");
      rd(F_STAT, 32'h0, "R1 fast status");
      chk_irq(1'b0, 1'b0, "R1 outputs after reset");

      // R2 map and read-back
      wr(F_MASK, 32'hA5A5_0000);
      rd(F_MASK, 32'hA5A5_0000, "R2 fast enable readback");
      rd(A_MASK, 32'h0, "R2 normal enable untouched");
      wr(F_KIND, 32'h0000_1234);
      rd(F_KIND, 32'h0000_1234, "R2 fast kind readback");
      rd(A_ACK, 32'h0, "R2 ack reads zero");
      rd(F_ACK, 32'h0, "R2 fast ack reads zero");
      rd(4'd6, 32'h0, "R2 unused code");
      wr(F_MASK, 32'h0);
      wr(F_KIND, 32'h0);

      // R3 adjusted input view
      set_lines(32'h0000_00F0);
      wr(A_POL, 32'h0000_0011);
      rd(A_SRC, 32'h0000_00E1, "R3 normal source");
      rd(F_SRC, 32'h0000_00F0, "R3 fast source");
      wr(A_POL, 32'h0);
      set_lines(32'h0);

      // R4 level lines, both polarities
      wr(A_MASK, 32'h3);
      wr(A_POL, 32'h2);
      chk_irq(1'b1, 1'b0, "R4 active-low line asserts");
      rd(A_STAT, 32'h2, "R4 active-low status");
      set_lines(32'h3);
      rd(A_STAT, 32'h1, "R4 active-high status");
      chk_irq(1'b1, 1'b0, "R4 high level irq");
      set_lines(32'h2);
      chk_irq(1'b0, 1'b0, "R4 both inactive");
      rd(A_STAT, 32'h0, "R4 status clear");
      wr(A_MASK, 32'h0);
      wr(A_POL, 32'h0);
      set_lines(32'h0);

      // R5 edge latching, rising on line 4 and falling on line 5
      wr(A_KIND, 32'h30);
      wr(A_POL, 32'h20);
      wr(A_MASK, 32'h30);
      rd(A_STAT, 32'h0, "R5 no edge yet");
      set_lines(32'h10);
      rd(A_STAT, 32'h10, "R5 rising edge latched");
      set_lines(32'h00);
      rd(A_STAT, 32'h10, "R5 latch holds after input drops");
      set_lines(32'h20);
      rd(A_STAT, 32'h10, "R5 opposite transition ignored");
      set_lines(32'h00);
      rd(A_STAT, 32'h30, "R5 falling edge latched");

      // R6 write-one acknowledge
      wr(A_ACK, 32'h10);
      rd(A_STAT, 32'h20, "R6 ack clears line 4 only");
      wr(A_ACK, 32'h0);
      rd(A_STAT, 32'h20, "R6 zero bits no effect");
      wr(A_ACK, 32'h20);
      rd(A_STAT, 32'h0, "R6 ack clears line 5");
      chk_irq(1'b0, 1'b0, "R6 output drops");

      // R7 same-cycle ack and new edge
      set_lines(32'h10);
      set_lines(32'h00);
      @(negedge clk);
      irq_lines = 32'h10;
      bus_valid = 1'b1; bus_write = 1'b1; bus_waddr = A_ACK; bus_wdata = 32'h10;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      rd(A_STAT, 32'h10, "R7 new edge beats ack");
      wr(A_ACK, 32'h10);
      rd(A_STAT, 32'h0, "R7 later ack clears");
      set_lines(32'h0);

      // R8 ack ignored on level lines
      wr(A_KIND, 32'h0);
      wr(A_POL, 32'h0);
      wr(A_MASK, 32'h1);
      set_lines(32'h1);
      wr(A_ACK, 32'hFFFF_FFFF);
      rd(A_STAT, 32'h1, "R8 level line survives ack");
      chk_irq(1'b1, 1'b0, "R8 output still high");
      set_lines(32'h0);
      rd(A_STAT, 32'h0, "R8 level follows input");

      // R9 enable gates status, latch persists
      wr(A_KIND, 32'h10);
      wr(A_MASK, 32'h0);
      set_lines(32'h10);
      set_lines(32'h0);
      chk_irq(1'b0, 1'b0, "R9 disabled line silent");
      rd(A_STAT, 32'h0, "R9 disabled status");
      wr(A_MASK, 32'h10);
      rd(A_STAT, 32'h10, "R9 latch shows after enable");
      chk_irq(1'b1, 1'b0, "R9 output after enable");
      wr(A_ACK, 32'h10);
      wr(A_KIND, 32'h0);
      wr(A_MASK, 32'h0);

      // R10 bank independence
      wr(F_MASK, 32'h4);
      set_lines(32'h4);
      chk_irq(1'b0, 1'b1, "R10 fast only");
      rd(F_STAT, 32'h4, "R10 fast status");
      rd(A_STAT, 32'h0, "R10 normal status untouched");
      wr(F_KIND, 32'h8);
      wr(F_MASK, 32'hC);
      set_lines(32'hC);
      rd(F_STAT, 32'hC, "R10 fast edge latched");
      set_lines(32'h0);
      rd(F_STAT, 32'h8, "R10 fast latch holds");
      chk_irq(1'b0, 1'b1, "R10 normal stays low");

      repeat (3) @(negedge clk);
      if (sb_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule